// File: doc/BRIEF.md
# Integer Register Bank with Zero/Stack-Pointer Alias

This block is the integer register bank of a small load/store core. It keeps thirty-one 64-bit registers, indices 0 to 30, and treats the top index, 31, as an alias. Index 31 has no storage behind it. A read of index 31 returns zero. A write to index 31 lands in a separate stack-pointer register. The current stack pointer is always visible on its own output, so address generation can use it without taking a read port.

The bank has two combinational read ports and one write port that updates on the clock edge. Each port has a width-select bit that picks either the full 64-bit register or a 32-bit view of its low half. A narrow read returns the low half with zeros above it. A narrow write clears the upper half of its target.

A separate link request writes the return address. It always goes to index 30 and overrides whatever index is on the write-index input. A read taken in the same cycle as a write to the same index returns the old contents, because there is no bypass path. A synchronous reset clears every register and the stack pointer.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all 31 registers and the stack pointer become zero. After reset, every read port returns 0 and `sp_out` is 0.
- R2: When `wr_en` is high, `link_en` is low, `wr_narrow` is 0 and `wr_idx` is between 0 and 30, a full-width write stores `wr_data`. The register with that index shows the value on either read port from the cycle after the edge. No other register changes.
- R3: A write with `wr_narrow` = 1 stores bits 31:0 of `wr_data` and clears bits 63:32 of the target. This holds for a general register and for the stack pointer.
- R4: A read port with its narrow bit at 1 returns bits 31:0 of the addressed register, and bits 63:32 of its output are 0.
- R5: A read port with index 31 returns zero in both full and narrow mode, whatever the stack pointer holds.
- R6: A write to index 31 (without `link_en`) updates `sp_out` from the next cycle and leaves registers 0 to 30 unchanged. `sp_out` changes only on such a write or on reset.
- R7: When `link_en` is high, the write goes to register 30 with the selected width, whatever the values of `wr_idx` and `wr_en`. With `link_en` high, the stack pointer is never written.
- R8: A read of an index that is written in the same cycle returns the value held before the edge. The new value appears from the next cycle.
- R9: When both `wr_en` and `link_en` are low, no register and no stack pointer changes, whatever the other write inputs carry.
- R10: The two read ports decode their index and width independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write port and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index (31 = zero alias) |
| rd_a_narrow | input | 1 | Read port A: 1 = low 32-bit view, 0 = full 64 bits |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index (31 = zero alias) |
| rd_b_narrow | input | 1 | Read port B: 1 = low 32-bit view, 0 = full 64 bits |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write request to `wr_idx` |
| link_en | input | 1 | Return-address write; forces the target to register 30 |
| wr_idx | input | 5 | Write index (31 steers to the stack pointer) |
| wr_narrow | input | 1 | Write width: 1 = 32-bit zero-extended, 0 = full 64 bits |
| wr_data | input | 64 | Write data |
| sp_out | output | 64 | Current stack-pointer value |

## Verification
The bench builds the bank with its default parameters: 64-bit data, a 32-bit narrow view and 5-bit indices. Together these give 31 real registers, with the alias at index 31 and the link target at index 30. With these values the narrow view covers exactly the low half, so every upper-half clearing case can be seen on the ports. The alias and link indices fall on the two highest codes, which lets the bench drive a link request with index 31 on `wr_idx` and confirm that the link target wins over the stack-pointer steering. A sweep over all 31 registers, followed by a stack-pointer write and a second sweep, reaches every storage slot and the claim that nothing else is disturbed.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Default geometry of the bank
  localparam int GPR_DATA_W   = 64;
  localparam int GPR_NARROW_W = 32;
  localparam int GPR_IDX_W    = 5;

  // Where a write request ends up after steering
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_GPR  = 2'd1,
    DST_SP   = 2'd2
  } gpr_dst_e;

endpackage

// File: rtl/gpr_wr_steer.sv
module gpr_wr_steer
  import gpr_pkg::*;
#(
  parameter int DATA_W   = GPR_DATA_W,
  parameter int NARROW_W = GPR_NARROW_W,
  parameter int IDX_W    = GPR_IDX_W
) (
  input  logic                          wr_en,
  input  logic                          link_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_narrow,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [(1<<IDX_W)-2:0]         reg_we,
  output logic                          sp_we,
  output logic [DATA_W-1:0]             wr_value,
  output gpr_dst_e                      dst_kind
);

  localparam int NUM_SLOTS = 1 << IDX_W;
  localparam int NUM_GPR   = NUM_SLOTS - 1;
  localparam logic [IDX_W-1:0] ALIAS_SEL = IDX_W'(NUM_SLOTS - 1);
  localparam logic [IDX_W-1:0] LINK_SEL  = IDX_W'(NUM_GPR - 1);

  // Format the write value: the narrow form keeps the low half, upper cleared
  function automatic logic [DATA_W-1:0] fit_write(input logic [DATA_W-1:0] d,
                                                  input logic narrow);
    logic [DATA_W-1:0] r;
    if (narrow) begin
      r = '0;
      r[NARROW_W-1:0] = d[NARROW_W-1:0];
    end else begin
      r = d;
    end
    return r;
  endfunction

  // Pick the effective destination index; the link request forces register 30
  function automatic logic [IDX_W-1:0] pick_dst(input logic lnk,
                                                input logic [IDX_W-1:0] idx);
    return lnk ? LINK_SEL : idx;
  endfunction

  logic             any_req;
  logic [IDX_W-1:0] dst_idx;

  always_comb begin
    any_req  = wr_en | link_en;
    dst_idx  = pick_dst(link_en, wr_idx);
    wr_value = fit_write(wr_data, wr_narrow);
    if (!any_req)
      dst_kind = DST_NONE;
    else if (dst_idx == ALIAS_SEL)
      dst_kind = DST_SP;
    else
      dst_kind = DST_GPR;
  end

  assign sp_we = (dst_kind == DST_SP);

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_we
    assign reg_we[g] = (dst_kind == DST_GPR) && (dst_idx == IDX_W'(g));
  end

endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int DATA_W  = 64,
  parameter int NUM_GPR = 31
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_GPR-1:0]              reg_we,
  input  logic                            sp_we,
  input  logic [DATA_W-1:0]               wr_value,
  output logic [NUM_GPR-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]               sp_q
);

  // One storage word per architectural register
  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (reg_we[g])
        regs[g] <= wr_value;
    end
  end

  // Stack pointer: the target of writes to the alias index
  always_ff @(posedge clk) begin
    if (rst)
      sp_q <= '0;
    else if (sp_we)
      sp_q <= wr_value;
  end

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 5
) (
  input  logic [IDX_W-1:0]                     idx,
  input  logic                                 narrow,
  input  logic [(1<<IDX_W)-2:0][DATA_W-1:0]    regs,
  output logic [DATA_W-1:0]                    data
);

  localparam logic [IDX_W-1:0] ALIAS_SEL = IDX_W'((1 << IDX_W) - 1);

  // Width view of a read: narrow keeps the low half, zero above
  function automatic logic [DATA_W-1:0] read_view(input logic [DATA_W-1:0] raw,
                                                  input logic narrow_i);
    logic [DATA_W-1:0] r;
    r = raw;
    if (narrow_i) r[DATA_W-1:NARROW_W] = '0;
    return r;
  endfunction

  logic [DATA_W-1:0] raw_word;

  always_comb begin
    raw_word = '0;
    if (idx != ALIAS_SEL)
      raw_word = regs[idx];
    data = read_view(raw_word, narrow);
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int DATA_W   = GPR_DATA_W,
  parameter int NARROW_W = GPR_NARROW_W,
  parameter int IDX_W    = GPR_IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic              rd_a_narrow,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              rd_b_narrow,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic              link_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_narrow,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sp_out
);

  localparam int NUM_GPR = (1 << IDX_W) - 1;
  localparam int NUM_RD  = 2;

  // Named internal events, visible to the bound checker
  logic [NUM_GPR-1:0]             reg_we;
  logic                           sp_we;
  logic [DATA_W-1:0]              wr_value;
  gpr_dst_e                       dst_kind;
  logic [NUM_GPR-1:0][DATA_W-1:0] regs;

  gpr_wr_steer #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .IDX_W   (IDX_W)
  ) u_steer (
    .wr_en    (wr_en),
    .link_en  (link_en),
    .wr_idx   (wr_idx),
    .wr_narrow(wr_narrow),
    .wr_data  (wr_data),
    .reg_we   (reg_we),
    .sp_we    (sp_we),
    .wr_value (wr_value),
    .dst_kind (dst_kind)
  );

  gpr_array #(
    .DATA_W (DATA_W),
    .NUM_GPR(NUM_GPR)
  ) u_array (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .sp_we   (sp_we),
    .wr_value(wr_value),
    .regs    (regs),
    .sp_q    (sp_out)
  );

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_v;
  logic [NUM_RD-1:0]             rd_nar_v;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_dat_v;

  assign rd_idx_v  = {rd_b_idx, rd_a_idx};
  assign rd_nar_v  = {rd_b_narrow, rd_a_narrow};
  assign rd_a_data = rd_dat_v[0];
  assign rd_b_data = rd_dat_v[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_rd_port #(
      .DATA_W  (DATA_W),
      .NARROW_W(NARROW_W),
      .IDX_W   (IDX_W)
    ) u_port (
      .idx   (rd_idx_v[p]),
      .narrow(rd_nar_v[p]),
      .regs  (regs),
      .data  (rd_dat_v[p])
    );
  end

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic [IDX_W-1:0]          rd_a_idx,
  input logic                      rd_a_narrow,
  input logic [DATA_W-1:0]         rd_a_data,
  input logic [IDX_W-1:0]          rd_b_idx,
  input logic                      rd_b_narrow,
  input logic [DATA_W-1:0]         rd_b_data,
  input logic                      wr_en,
  input logic                      link_en,
  input logic [IDX_W-1:0]          wr_narrow_dummy_idx,
  input logic                      wr_narrow,
  input logic [DATA_W-1:0]         wr_data,
  input logic [DATA_W-1:0]         sp_out,
  input logic [(1<<IDX_W)-2:0]     reg_we,
  input logic                      sp_we
);

  localparam int NUM_GPR = (1 << IDX_W) - 1;
  localparam int LINK_I  = NUM_GPR - 1;
  localparam logic [IDX_W-1:0] ALIAS_SEL = IDX_W'((1 << IDX_W) - 1);

  AST_RST_CLEARS_SP: assert property (@(posedge clk) $past(rst) |-> sp_out == '0); // R1
  AST_ALIAS_READ_A: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == ALIAS_SEL |-> rd_a_data == '0); // R5
  AST_ALIAS_READ_B: assert property (@(posedge clk) disable iff (rst)
    rd_b_idx == ALIAS_SEL |-> rd_b_data == '0); // R5
  AST_NARROW_READ_A: assert property (@(posedge clk) disable iff (rst)
    rd_a_narrow |-> rd_a_data[DATA_W-1:NARROW_W] == '0); // R4
  AST_NARROW_READ_B: assert property (@(posedge clk) disable iff (rst)
    rd_b_narrow |-> rd_b_data[DATA_W-1:NARROW_W] == '0); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en || link_en) |-> (reg_we == '0 && !sp_we)); // R9
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, sp_we})); // R2
  AST_LINK_TARGET: assert property (@(posedge clk) disable iff (rst)
    link_en |-> (reg_we[LINK_I] && $countones(reg_we) == 1 && !sp_we)); // R7
  AST_SP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sp_we |=> $stable(sp_out)); // R6
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (rst)
    sp_we |=> sp_out == ($past(wr_narrow) ? DATA_W'($past(wr_data[NARROW_W-1:0]))
                                           : $past(wr_data))); // R3

endmodule

bind gpr_bank gpr_bank_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk                (clk),
  .rst                (rst),
  .rd_a_idx           (rd_a_idx),
  .rd_a_narrow        (rd_a_narrow),
  .rd_a_data          (rd_a_data),
  .rd_b_idx           (rd_b_idx),
  .rd_b_narrow        (rd_b_narrow),
  .rd_b_data          (rd_b_data),
  .wr_en              (wr_en),
  .link_en            (link_en),
  .wr_narrow_dummy_idx(wr_idx),
  .wr_narrow          (wr_narrow),
  .wr_data            (wr_data),
  .sp_out             (sp_out),
  .reg_we             (reg_we),
  .sp_we              (sp_we)
);

// File: tb/sim_gpr_bank.sv
module sim_gpr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_narrow = 1'b0, rd_b_narrow = 1'b0;
  logic        wr_en = 1'b0, link_en = 1'b0, wr_narrow = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_a_data, rd_b_data, sp_out;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_bank u0 (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .link_en(link_en), .wr_idx(wr_idx),
    .wr_narrow(wr_narrow), .wr_data(wr_data), .sp_out(sp_out)
  );

  typedef struct packed {
    logic        we;
    logic        lnk;
    logic [4:0]  widx;
    logic        wn;
    logic [63:0] wdata;
    logic [4:0]  aidx;
    logic        an;
    logic [4:0]  bidx;
    logic        bn;
    logic [63:0] expa;
    logic [63:0] expb;
    logic [63:0] expsp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    // R2 full write, R4 narrow read of the same register
    '{1'b1, 1'b0, 5'd3, 1'b0, 64'hDEADBEEF_01234567, 5'd3, 1'b0, 5'd3, 1'b1,
      64'hDEADBEEF_01234567, 64'h00000000_01234567, 64'h0},
    // R3 narrow write clears upper half, R10 ports independent
    '{1'b1, 1'b0, 5'd5, 1'b1, 64'hFFFFFFFF_89ABCDEF, 5'd5, 1'b0, 5'd3, 1'b0,
      64'h00000000_89ABCDEF, 64'hDEADBEEF_01234567, 64'h0},
    // R5 alias reads zero, R6 write to 31 lands in the stack pointer
    '{1'b1, 1'b0, 5'd31, 1'b0, 64'h00007FFF_FFF00000, 5'd31, 1'b0, 5'd31, 1'b1,
      64'h0, 64'h0, 64'h00007FFF_FFF00000},
    // R7 link writes register 30 even with wr_en low and wr_idx = 7
    '{1'b0, 1'b1, 5'd7, 1'b0, 64'h00000000_00401000, 5'd30, 1'b0, 5'd7, 1'b0,
      64'h00000000_00401000, 64'h0, 64'h00007FFF_FFF00000},
    // R9 no request: nothing changes
    '{1'b0, 1'b0, 5'd3, 1'b0, 64'h11111111_11111111, 5'd3, 1'b0, 5'd5, 1'b1,
      64'hDEADBEEF_01234567, 64'h00000000_89ABCDEF, 64'h00007FFF_FFF00000},
    // R2 all-ones into register 0, R4 narrow view
    '{1'b1, 1'b0, 5'd0, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 5'd0, 1'b1, 5'd0, 1'b0,
      64'h00000000_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h00007FFF_FFF00000},
    // R3 narrow write to the stack pointer, R6 registers untouched
    '{1'b1, 1'b0, 5'd31, 1'b1, 64'hABCD0000_00001000, 5'd0, 1'b0, 5'd30, 1'b0,
      64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00401000, 64'h00000000_00001000},
    // R7 link beats the alias index; narrow link write
    '{1'b1, 1'b1, 5'd31, 1'b1, 64'h12345678_9ABCDEF0, 5'd30, 1'b0, 5'd31, 1'b0,
      64'h00000000_9ABCDEF0, 64'h0, 64'h00000000_00001000}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd_a_idx = 5'd3; rd_b_idx = 5'd30;
    #1;
    check("R1", "reset reg3", rd_a_data, 64'h0);
    check("R1", "reset reg30", rd_b_data, 64'h0);
    check("R1", "reset sp", sp_out, 64'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr_en = VECS[i].we; link_en = VECS[i].lnk; wr_idx = VECS[i].widx;
      wr_narrow = VECS[i].wn; wr_data = VECS[i].wdata;
      rd_a_idx = VECS[i].aidx; rd_a_narrow = VECS[i].an;
      rd_b_idx = VECS[i].bidx; rd_b_narrow = VECS[i].bn;
      @(negedge clk);
      wr_en = 1'b0; link_en = 1'b0;
      #1;
      check($sformatf("vec%0d", i), "port A", rd_a_data, VECS[i].expa);
      check($sformatf("vec%0d", i), "port B", rd_b_data, VECS[i].expb);
      check($sformatf("vec%0d", i), "sp", sp_out, VECS[i].expsp);
    end

    // R8: same-cycle read returns the old value
    @(negedge clk);
    rd_a_idx = 5'd3; rd_a_narrow = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd3; wr_narrow = 1'b0; wr_data = 64'h55555555_55555555;
    #1;
    check("R8", "read during write", rd_a_data, 64'hDEADBEEF_01234567);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R8", "read after write", rd_a_data, 64'h55555555_55555555);

    // R2 sweep: every register gets its own pattern
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(i); wr_narrow = 1'b0;
      wr_data = 64'h01010101_01010101 * (64'(i) + 64'd1);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_b_narrow = 1'b0;
    for (int i = 0; i < 31; i++) begin
      rd_b_idx = 5'(i);
      #1;
      check("R2", $sformatf("sweep reg%0d", i), rd_b_data,
            64'h01010101_01010101 * (64'(i) + 64'd1));
    end

    // R6: stack pointer write leaves all registers unchanged
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd31; wr_narrow = 1'b0; wr_data = 64'h0000CAFE_0000BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R6", "sp after write", sp_out, 64'h0000CAFE_0000BEEF);
    rd_a_narrow = 1'b0;
    for (int i = 0; i < 31; i++) begin
      rd_a_idx = 5'(i);
      #1;
      check("R6", $sformatf("reg%0d kept", i), rd_a_data,
            64'h01010101_01010101 * (64'(i) + 64'd1));
    end

    // R1: reset in mid-run clears registers and the stack pointer
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_a_idx = 5'd17; rd_b_idx = 5'd30;
    #1;
    check("R1", "reset reg17", rd_a_data, 64'h0);
    check("R1", "reset reg30", rd_b_data, 64'h0);
    check("R1", "reset sp", sp_out, 64'h0);

    finish_run();
  end

endmodule